// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of several DMA channels is served next. Each channel has a raw request line whose active level can be set by software. It also has a mask bit and a software request bit. The block turns these into one effective request per channel. It then picks a single winner, either in a fixed order or in an order that rotates after every completed service. The winner is registered as a grant and handed to the transfer sequencer as a channel number with a valid flag. The acknowledge lines go out with a selectable active level.

The link to the sequencer works as a valid/ready pair. `gnt_valid` offers the grant, and `svc_done` is the ready that takes it. A grant stays frozen, with the same channel and the same acknowledge, while `svc_done` is low. This holds even if the request lines change or a higher-priority request shows up. The grant is retired on the clock edge where `svc_done` is sampled high. In rotating mode the priority order moves on at that same edge. A global halt bit stops new grants from being issued.

Top module: `dma_prio_arb`

## Requirements
- R1: An asynchronous reset (`rst_n` low), or `mclr` sampled high at a clock edge, clears the grant. After that, `gnt_valid` is 0, `gnt_chan` is 0, every `dack` line is at its inactive level, and the rotation base returns to channel 0, so channel 0 ranks highest.
- R2: With `cmd_dreq_low` = 0, a `dreq_raw` line requests when it is 1. With `cmd_dreq_low` = 1, it requests when it is 0.
- R3: `mask[i]` = 1 blocks the hardware request of channel i.
- R4: `sw_req[i]` = 1 requests channel i. This works whatever the value of `mask[i]`, `dreq_raw[i]` or `cmd_dreq_low`.
- R5: With `cmd_rotate` = 0, the lowest-numbered requesting channel wins.
- R6: When a grant on channel c is retired while `cmd_rotate` = 1, the order becomes c+1, c+2, … wrapping modulo 4. Channel c is now lowest. With `cmd_rotate` = 1, the winner is the first requesting channel in this order.
- R7: While `cmd_halt` = 1, no new grant is issued.
- R8: With no grant held, the grant for the current effective requests appears on the clock edge that follows. Between that edge and the edge where `svc_done` is sampled high, the grant stays unchanged. At that edge `gnt_valid` drops. A new grant can appear one edge later at the earliest.
- R9: With `cmd_dack_high` = 0, the granted channel's `dack` line is 0 and the others are 1. With `cmd_dack_high` = 1, the levels are reversed. With no grant, all lines are inactive. The level follows `cmd_dack_high` within the same cycle.
- R10: `gnt_vec` has exactly bit `gnt_chan` set while `gnt_valid` is 1, and is all zero otherwise.
- R11: Retiring a grant while `cmd_rotate` = 0 leaves the rotation base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Synchronous master clear |
| dreq_raw | input | 4 | Raw channel request lines |
| mask | input | 4 | Per-channel hardware request mask, 1 = blocked |
| sw_req | input | 4 | Software request bits |
| cmd_rotate | input | 1 | 0 = fixed order, 1 = rotating order |
| cmd_dreq_low | input | 1 | 1 = request lines active low |
| cmd_dack_high | input | 1 | 1 = acknowledge lines active high |
| cmd_halt | input | 1 | 1 = issue no new grants |
| svc_done | input | 1 | Sequencer accepts and retires the held grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_chan | output | 2 | Granted channel number |
| gnt_vec | output | 4 | One-hot grant |
| dack | output | 4 | Channel acknowledge lines |

## Verification
A grant is registered, so `gnt_valid`, `gnt_chan` and `gnt_vec` change only on the clock edge after the requests settle. Retirement and the rotation step land on the edge where `svc_done` is high. `dack` is combinational in `cmd_dack_high`, so its level responds within the same cycle. The bench therefore applies inputs on the falling edge and first confirms that nothing has changed yet. It then samples one time unit after the next rising edge. Rotation is checked through the winner of the following grant, and the hold rule is checked by changing the requests while a grant is pending.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned ARB_NCH_DEF = 4;

  // next channel index after v, wrapping at n
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_NCH_DEF
) (
  input  logic [NCH-1:0] dreq_raw,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] sw_req,
  input  logic           dreq_low,
  output logic [NCH-1:0] eff_req
);

  logic [NCH-1:0] hw_act;

  // R2 level conversion, R3 masking, R4 unmaskable software requests
  always_comb begin
    hw_act  = dreq_low ? ~dreq_raw : dreq_raw;
    eff_req = (hw_act & ~mask) | sw_req;
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_NCH_DEF,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic [CW-1:0]  top,
  input  logic           rotate,
  output logic           found,
  output logic [CW-1:0]  win
);

  logic [CW-1:0] base;
  logic [CW:0]   idx;

  // R5 fixed scan from 0, R6 scan from the rotation base
  always_comb begin
    base  = rotate ? top : '0;
    found = 1'b0;
    win   = '0;
    idx   = '0;
    for (int k = 0; k < int'(NCH); k++) begin
      idx = {1'b0, base} + k[CW:0];
      if (idx >= (CW+1)'(NCH)) idx = idx - (CW+1)'(NCH);
      if (!found && req[idx[CW-1:0]]) begin
        found = 1'b1;
        win   = idx[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/dma_grant_ctl.sv
module dma_grant_ctl #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_NCH_DEF,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr,
  input  logic          found,
  input  logic [CW-1:0] win,
  input  logic          halt,
  input  logic          rotate,
  input  logic          svc_done,
  output logic          gnt_valid,
  output logic [CW-1:0] gnt_chan,
  output logic [CW-1:0] top
);

  logic [CW-1:0] after_chan;
  assign after_chan = CW'(dma_arb_pkg::wrap_inc(int'(gnt_chan), NCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
      top       <= '0;
    end else if (mclr) begin
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
      top       <= '0;
    end else if (gnt_valid) begin
      if (svc_done) begin
        gnt_valid <= 1'b0;
        gnt_chan  <= '0;
        if (rotate) top <= after_chan;
      end
    end else if (found && !halt) begin
      gnt_valid <= 1'b1;
      gnt_chan  <= win;
    end
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!gnt_valid && top == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !svc_done && !mclr) |=> (gnt_valid && $stable(gnt_chan)));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && svc_done) |=> !gnt_valid);
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && halt) |=> !gnt_valid);
  a_r11_fixed_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && svc_done && !rotate && !mclr) |=> $stable(top));
  a_r6_base_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && svc_done && rotate && !mclr) |=> (top != $past(gnt_chan)));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_NCH_DEF,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mclr,
  input  logic [NCH-1:0] dreq_raw,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] sw_req,
  input  logic           cmd_rotate,
  input  logic           cmd_dreq_low,
  input  logic           cmd_dack_high,
  input  logic           cmd_halt,
  input  logic           svc_done,
  output logic           gnt_valid,
  output logic [CW-1:0]  gnt_chan,
  output logic [NCH-1:0] gnt_vec,
  output logic [NCH-1:0] dack
);

  logic [NCH-1:0] eff_req;
  logic           found;
  logic [CW-1:0]  win;
  logic [CW-1:0]  top;

  dma_req_cond #(.NCH(NCH)) u_cond (
    .dreq_raw (dreq_raw),
    .mask     (mask),
    .sw_req   (sw_req),
    .dreq_low (cmd_dreq_low),
    .eff_req  (eff_req)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req    (eff_req),
    .top    (top),
    .rotate (cmd_rotate),
    .found  (found),
    .win    (win)
  );

  dma_grant_ctl #(.NCH(NCH)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .found     (found),
    .win       (win),
    .halt      (cmd_halt),
    .rotate    (cmd_rotate),
    .svc_done  (svc_done),
    .gnt_valid (gnt_valid),
    .gnt_chan  (gnt_chan),
    .top       (top)
  );

  // R10 one-hot decode, R9 acknowledge level
  generate
    for (genvar g = 0; g < int'(NCH); g++) begin : g_ack
      assign gnt_vec[g] = gnt_valid && (gnt_chan == CW'(g));
      assign dack[g]    = cmd_dack_high ? gnt_vec[g] : ~gnt_vec[g];
    end
  endgenerate

  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (($past(eff_req) & gnt_vec) != '0));
  a_r5_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_valid) && !$past(cmd_rotate)) |-> (($past(eff_req) & (gnt_vec - 1'b1)) == '0));
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $onehot(gnt_vec));

endmodule

// File: tb/dma_prio_arb_test.sv
module dma_prio_arb_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mclr = 1'b0;
  logic [3:0] dreq_raw = '0, mask = '0, sw_req = '0;
  logic       cmd_rotate = 0, cmd_dreq_low = 0, cmd_dack_high = 0, cmd_halt = 0;
  logic       svc_done = 0;
  logic       gnt_valid;
  logic [1:0] gnt_chan;
  logic [3:0] gnt_vec, dack;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .dreq_raw(dreq_raw), .mask(mask),
    .sw_req(sw_req), .cmd_rotate(cmd_rotate), .cmd_dreq_low(cmd_dreq_low),
    .cmd_dack_high(cmd_dack_high), .cmd_halt(cmd_halt), .svc_done(svc_done),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_vec(gnt_vec), .dack(dack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // {dreq, mask, sw, rotate, dreq_low, dack_high, halt, exp_valid, exp_chan, exp_dack}
  localparam int NV = 16;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1110}, // R5
    {4'b1010, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 4'b1101}, // R5
    {4'b1010, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0111}, // R3
    {4'b1010, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 4'b0001}, // R2 R9
    {4'b0000, 4'b1111, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 4'b1011}, // R4
    {4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b1111}, // R7
    {4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1111}, // R3
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1110}, // R2
    {4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1110}, // R6 base->1
    {4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 4'b1101}, // R6 base->2
    {4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1110}, // R11 base stays 2
    {4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 4'b1011}, // R6 R11 base->3
    {4'b1001, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0111}, // R6 base->0
    {4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1110}, // R6 base->1
    {4'b1001, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0111}, // R6 base->0
    {4'b0110, 4'b0110, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0111}  // R3 R4
  };

  task automatic release_grant();
    @(negedge clk); svc_done = 1'b1;
    @(posedge clk); #1;
    chk("R8 retire", gnt_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 valid", gnt_valid, 0);
    chk("R1 dack", dack, 4'b1111);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 chan", gnt_chan, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      svc_done      = 1'b0;
      dreq_raw      = VEC[i][22:19];
      mask          = VEC[i][18:15];
      sw_req        = VEC[i][14:11];
      cmd_rotate    = VEC[i][10];
      cmd_dreq_low  = VEC[i][9];
      cmd_dack_high = VEC[i][8];
      cmd_halt      = VEC[i][7];
      #1;
      chk("R8 no early grant", gnt_valid, 0);
      @(posedge clk); #1;
      chk("R2 R3 R4 R5 R6 R7 R11 valid", gnt_valid, VEC[i][6]);
      chk("R5 R6 chan", gnt_chan, VEC[i][5:4]);
      chk("R9 dack", dack, VEC[i][3:0]);
      chk("R10 vec", gnt_vec, VEC[i][6] ? (4'b0001 << VEC[i][5:4]) : 4'b0000);
      release_grant();
    end

    // R8 hold against request changes, R9 same-cycle polarity
    @(negedge clk);
    svc_done = 0; mask = '0; sw_req = '0; cmd_rotate = 0; cmd_dreq_low = 0;
    cmd_dack_high = 0; cmd_halt = 0; dreq_raw = 4'b0100;
    @(posedge clk); #1;
    chk("R8 grant ch2", gnt_chan, 2);
    @(negedge clk); dreq_raw = 4'b0001;
    @(posedge clk); #1;
    chk("R8 held chan", gnt_chan, 2);
    chk("R8 held valid", gnt_valid, 1);
    @(negedge clk); cmd_dack_high = 1'b1; #1;
    chk("R9 dack flips", dack, 4'b0100);
    cmd_dack_high = 1'b0;
    release_grant();
    @(negedge clk); svc_done = 1'b0;
    @(posedge clk); #1;
    chk("R8 next grant", gnt_chan, 0);
    release_grant();

    // R1 master clear resets rotation base and drops a held grant
    @(negedge clk); svc_done = 0; cmd_rotate = 1; dreq_raw = 4'b0010;
    @(posedge clk); #1;
    chk("R6 grant ch1", gnt_chan, 1);
    release_grant();
    @(negedge clk); svc_done = 0; mclr = 1; dreq_raw = 4'b0000;
    @(negedge clk); mclr = 0; dreq_raw = 4'b1111;
    @(posedge clk); #1;
    chk("R1 base cleared", gnt_chan, 0);
    chk("R1 grant present", gnt_valid, 1);
    @(negedge clk); mclr = 1;
    @(posedge clk); #1;
    chk("R1 mclr drops grant", gnt_valid, 0);
    chk("R1 dack inactive", dack, 4'b1111);
    @(negedge clk); mclr = 0; dreq_raw = 4'b0000;
    @(posedge clk); #1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule